// File: doc/BRIEF.md
# Indirect Extended Register Access Bridge

This block sits behind a 32-entry management register port (5-bit register address, 16-bit data, one write strobe and one read strobe) and gives that port a way to reach a 64K-entry extended register space. It does this through two windows that it owns: a control register at address 0x0D and an address/data window at 0x0E. The control register holds a device address that must match a fixed vendor value, and a two-bit function that decides what the window at 0x0E reaches. The window reaches either a 16-bit address pointer or the register that pointer selects.

Every other direct address passes straight through to the normal register file port. When the pointer selects an address below 32, an indirect data access goes to that same register file. Indirect accesses to the block's own two windows are refused. When the pointer is 32 or above, the access goes to the extended register port with the full pointer as the address. Read data is combinational in the cycle of the read strobe. The pointer, the control register and any post-increment update at the next rising clock edge.

Top module: `mmd_indirect_access`

## Requirements
- R1: After reset the control register reads 0x0000 (function 00, device address 00000) and the address pointer is 0x0000.
- R2: A write to address 0x0D stores bits [15:14] as the function and bits [4:0] as the device address. A read of 0x0D returns those fields with every other bit zero. Accesses to 0x0D produce no strobe on either downstream port.
- R3: While the stored device address is not 11111, every access to 0x0E is ignored. A read returns 0x0000, no downstream strobe is produced and the pointer does not change.
- R4: With function 00, a write to 0x0E loads the pointer with the write data and a read of 0x0E returns the pointer. Repeated accesses keep reaching the pointer.
- R5: With function 01, accesses to 0x0E reach the register selected by the pointer, and the pointer never changes.
- R6: With function 10, the pointer increases by one after each accepted read or write through 0x0E.
- R7: With function 11, the pointer increases by one after each accepted write through 0x0E and stays unchanged after reads.
- R8: A post-increment from 0xFFFF wraps the pointer to 0x0000.
- R9: An accepted indirect data access with pointer ≥ 32 strobes the extended port at the pointer address and returns its read data. With pointer < 32 it strobes the register file port at pointer[4:0] and returns that port's read data. Write data is forwarded unchanged.
- R10: An indirect data access whose pointer is 0x000D or 0x000E is ignored. A read returns 0x0000, no strobe is produced and there is no post-increment.
- R11: A direct access to any address other than 0x0D and 0x0E strobes the register file port at that address and returns its read data.
- R12: When the write and read strobes are both high, the access is handled as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 5 | Register address of the access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid during a read strobe |
| std_addr | output | 5 | Register file address |
| std_wr | output | 1 | Register file write strobe |
| std_rd | output | 1 | Register file read strobe |
| std_wdata | output | 16 | Register file write data |
| std_rdata | input | 16 | Register file read data |
| ext_addr | output | 16 | Extended register address |
| ext_wr | output | 1 | Extended register write strobe |
| ext_rd | output | 1 | Extended register read strobe |
| ext_wdata | output | 16 | Extended register write data |
| ext_rdata | input | 16 | Extended register read data |

## Verification
A corrupted pointer does not show at once. It shows on the next window access: as a wrong `ext_addr` or `std_addr` on a data access, or as a wrong `host_rdata` on a pointer read in function 00. The bench therefore checks every access's strobes, addresses and read data against its own model, so a drift is caught on the first access after it. A wrong increment rule gives an off-by-one address one access later. A broken device-address gate or self-window refusal shows up in the same cycle, as a strobe that should be absent or a non-zero read.

// File: rtl/mmd_pkg.sv
// Package: shared widths, window function encoding and control fields for
// the indirect extended register bridge. Assumes 16-bit register data.
package mmd_pkg;

    localparam int DATA_W = 16;
    localparam int REG_AW = 5;
    localparam int PTR_W  = 16;
    localparam int DEV_W  = 5;

    // Window function held in control bits [15:14]
    typedef enum logic [1:0] {
        FN_ADDR   = 2'b00,
        FN_DATA   = 2'b01,
        FN_INC_RW = 2'b10,
        FN_INC_WR = 2'b11
    } mmd_fn_e;

    typedef struct packed {
        mmd_fn_e          fn;
        logic [DEV_W-1:0] devad;
    } mmd_ctrl_t;

endpackage

// File: rtl/mmd_ctrl_reg.sv
// Control register: keeps the window function (top two data bits) and the
// device address (low DEV_W bits). Unused bits read back as zero.
// Assumes DATA_W > DEV_W + 2.
module mmd_ctrl_reg
    import mmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int DVW = DEV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output mmd_ctrl_t     ctrl,
    output logic [DW-1:0] rdata
);

    localparam int FN_LSB = DW - 2;

    logic [1:0]     fn_q;
    logic [DVW-1:0] dev_q;

    // Capture the two fields on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_q  <= 2'b00;
            dev_q <= '0;
        end else if (wr_en) begin
            fn_q  <= wdata[DW-1:FN_LSB];
            dev_q <= wdata[DVW-1:0];
        end
    end

    assign ctrl.fn    = mmd_fn_e'(fn_q);
    assign ctrl.devad = dev_q;

    // Readback: fields at their positions, zero elsewhere
    for (genvar b = 0; b < DW; b++) begin : g_rb
        if (b < DVW) begin : g_dev
            assign rdata[b] = dev_q[b];
        end else if (b >= FN_LSB) begin : g_fn
            assign rdata[b] = fn_q[b-FN_LSB];
        end else begin : g_zero
            assign rdata[b] = 1'b0;
        end
    end

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata[DW-1:FN_LSB] == $past(wdata[DW-1:FN_LSB])) &&
                  (rdata[DVW-1:0] == $past(wdata[DVW-1:0])));

endmodule

// File: rtl/mmd_addr_ptr.sv
// Address pointer: loads from the window, or steps by one with natural
// wrap. Assumes load and inc are never requested together (load wins).
module mmd_addr_ptr #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          inc,
    output logic [PW-1:0] ptr
);

    // Pointer register with load priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == $past(load_val));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> ptr == PW'($past(ptr) + 1'b1));

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (&ptr)) |=> ptr == '0);

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(ptr));

endmodule

// File: rtl/mmd_access_decode.sv
// Access decoder: classifies each host access as control, window or
// pass-through, applies the device gate and self-window refusal, steers
// strobes and read data, and requests pointer loads and increments.
// Purely combinational; clk and rst_n serve only its assertions.
module mmd_access_decode
    import mmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = REG_AW,
    parameter int PW = PTR_W,
    parameter logic [AW-1:0] CTRL_ADDR = 5'h0D,
    parameter logic [AW-1:0] DATA_ADDR = 5'h0E,
    parameter logic [DEV_W-1:0] VENDOR_DEV = 5'h1F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  mmd_ctrl_t     ctrl,
    input  logic [DW-1:0] ctrl_rdata,
    output logic          ctrl_wr,
    input  logic [PW-1:0] ptr,
    output logic          ptr_load,
    output logic          ptr_inc,
    output logic [AW-1:0] std_addr,
    output logic          std_wr,
    output logic          std_rd,
    output logic [DW-1:0] std_wdata,
    input  logic [DW-1:0] std_rdata,
    output logic [PW-1:0] ext_addr,
    output logic          ext_wr,
    output logic          ext_rd,
    output logic [DW-1:0] ext_wdata,
    input  logic [DW-1:0] ext_rdata
);

    localparam logic [PW-1:0] STD_TOP = PW'(2 ** AW);

    logic wr, rd;
    logic hit_ctrl, hit_data, hit_std;
    logic dev_ok, data_fn, ptr_low, ptr_self;
    logic ind_go, ind_std, ind_ext;

    // Write wins over a simultaneous read
    always_comb begin
        wr = host_wr;
        rd = host_rd & ~host_wr;
    end

    // Classify the access and the pointer target
    always_comb begin
        hit_ctrl = (host_addr == CTRL_ADDR);
        hit_data = (host_addr == DATA_ADDR);
        hit_std  = !hit_ctrl && !hit_data;
        dev_ok   = (ctrl.devad == VENDOR_DEV);
        data_fn  = (ctrl.fn != FN_ADDR);
        ptr_low  = (ptr < STD_TOP);
        ptr_self = ptr_low && ((ptr[AW-1:0] == CTRL_ADDR) ||
                               (ptr[AW-1:0] == DATA_ADDR));
        ind_go   = hit_data && dev_ok && data_fn && !ptr_self;
        ind_std  = ind_go && ptr_low;
        ind_ext  = ind_go && !ptr_low;
    end

    // Downstream strobes and addresses
    always_comb begin
        std_addr  = hit_std ? host_addr : ptr[AW-1:0];
        std_wr    = wr && (hit_std || ind_std);
        std_rd    = rd && (hit_std || ind_std);
        std_wdata = host_wdata;
        ext_addr  = ptr;
        ext_wr    = wr && ind_ext;
        ext_rd    = rd && ind_ext;
        ext_wdata = host_wdata;
        ctrl_wr   = wr && hit_ctrl;
    end

    // Pointer load in address function and post-increment by function
    always_comb begin
        ptr_load = wr && hit_data && dev_ok && !data_fn;
        unique case (ctrl.fn)
            FN_INC_RW: ptr_inc = ind_go && (wr || rd);
            FN_INC_WR: ptr_inc = ind_go && wr;
            default:   ptr_inc = 1'b0;
        endcase
    end

    // Read data steering; refused accesses read zero
    always_comb begin
        if (hit_ctrl)      host_rdata = ctrl_rdata;
        else if (hit_std)  host_rdata = std_rdata;
        else if (!dev_ok)  host_rdata = '0;
        else if (!data_fn) host_rdata = DW'(ptr);
        else if (ind_std)  host_rdata = std_rdata;
        else if (ind_ext)  host_rdata = ext_rdata;
        else               host_rdata = '0;
    end

    // R3
    dev_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == DATA_ADDR && ctrl.devad != VENDOR_DEV) |->
            (!std_wr && !std_rd && !ext_wr && !ext_rd && !ptr_inc && !ptr_load &&
             host_rdata == '0));

    // R10
    self_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == DATA_ADDR && ctrl.fn != FN_ADDR &&
         (ptr == PW'(CTRL_ADDR) || ptr == PW'(DATA_ADDR))) |->
            (!std_wr && !std_rd && !ext_wr && !ext_rd && !ptr_inc && host_rdata == '0));

    // R7
    wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && ctrl.fn == FN_INC_WR) |-> !ptr_inc);

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({std_wr, std_rd, ext_wr, ext_rd}));

    // R12
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rd) |-> (!std_rd && !ext_rd));

endmodule

// File: rtl/mmd_indirect_access.sv
// Top: indirect extended register bridge. Joins the control register, the
// address pointer and the access decoder. Assumes one access per strobe
// cycle and read data from both downstream ports valid in the same cycle.
module mmd_indirect_access
    import mmd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = REG_AW,
    parameter int PW = PTR_W,
    parameter logic [AW-1:0] CTRL_ADDR = 5'h0D,
    parameter logic [AW-1:0] DATA_ADDR = 5'h0E,
    parameter logic [DEV_W-1:0] VENDOR_DEV = 5'h1F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] std_addr,
    output logic          std_wr,
    output logic          std_rd,
    output logic [DW-1:0] std_wdata,
    input  logic [DW-1:0] std_rdata,
    output logic [PW-1:0] ext_addr,
    output logic          ext_wr,
    output logic          ext_rd,
    output logic [DW-1:0] ext_wdata,
    input  logic [DW-1:0] ext_rdata
);

    mmd_ctrl_t     ctrl;
    logic [DW-1:0] ctrl_rdata;
    logic          ctrl_wr;
    logic [PW-1:0] ptr;
    logic          ptr_load;
    logic          ptr_inc;

    mmd_ctrl_reg #(.DW(DW), .DVW(DEV_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctrl_wr),
        .wdata (host_wdata),
        .ctrl  (ctrl),
        .rdata (ctrl_rdata)
    );

    mmd_addr_ptr #(.PW(PW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (PW'(host_wdata)),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    mmd_access_decode #(
        .DW(DW), .AW(AW), .PW(PW),
        .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR), .VENDOR_DEV(VENDOR_DEV)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ctrl       (ctrl),
        .ctrl_rdata (ctrl_rdata),
        .ctrl_wr    (ctrl_wr),
        .ptr        (ptr),
        .ptr_load   (ptr_load),
        .ptr_inc    (ptr_inc),
        .std_addr   (std_addr),
        .std_wr     (std_wr),
        .std_rd     (std_rd),
        .std_wdata  (std_wdata),
        .std_rdata  (std_rdata),
        .ext_addr   (ext_addr),
        .ext_wr     (ext_wr),
        .ext_rd     (ext_rd),
        .ext_wdata  (ext_wdata),
        .ext_rdata  (ext_rdata)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctrl_rdata == '0 && ptr == '0));

endmodule

// File: tb/tb_mmd_indirect_access.sv
// Bench: directed corner cases, then seeded random accesses, all compared
// with a bench model of control fields, pointer and register file.
module tb_mmd_indirect_access;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [4:0]  std_addr;
    logic        std_wr, std_rd;
    logic [15:0] std_wdata, std_rdata;
    logic [15:0] ext_addr;
    logic        ext_wr, ext_rd;
    logic [15:0] ext_wdata, ext_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] std_mem [32];
    logic [1:0]  m_fn = 2'b00;
    logic [4:0]  m_dev = 5'd0;
    logic [15:0] m_ptr = 16'h0000;

    always #2.5 clk = ~clk;

    mmd_indirect_access dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .std_addr(std_addr), .std_wr(std_wr), .std_rd(std_rd),
        .std_wdata(std_wdata), .std_rdata(std_rdata),
        .ext_addr(ext_addr), .ext_wr(ext_wr), .ext_rd(ext_rd),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    // Register file stand-in and extended space as a computed pattern
    assign std_rdata = std_mem[std_addr];
    assign ext_rdata = ext_addr ^ 16'h5AA5;
    always @(posedge clk) if (std_wr) std_mem[std_addr] <= std_wdata;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: predict, drive at negedge, sample, then update model
    task automatic acc(input logic w, input logic r, input logic [4:0] a,
                       input logic [15:0] d, input string force_tag);
        logic ew, er;
        logic [15:0] exp_rd, n_ptr;
        logic e_sw, e_sr, e_ew, e_er;
        logic [4:0] e_sa;
        logic [15:0] e_ea;
        logic [40:0] ev, av;
        string t, rt;
        ew = w; er = r & ~w;
        exp_rd = '0; n_ptr = m_ptr;
        e_sw = 0; e_sr = 0; e_ew = 0; e_er = 0; e_sa = '0; e_ea = '0;
        t = ""; rt = "";
        if (a == 5'h0D) begin
            t = "R2"; exp_rd = {m_fn, 9'b0, m_dev};
        end else if (a == 5'h0E) begin
            if (m_dev != 5'h1F) begin
                t = "R3";
            end else if (m_fn == 2'b00) begin
                t = "R4"; exp_rd = m_ptr;
                if (ew) n_ptr = d;
            end else begin
                t = (m_fn == 2'b01) ? "R5" : (m_fn == 2'b10) ? "R6" : "R7";
                if (m_ptr == 16'h000D || m_ptr == 16'h000E) begin
                    t = "R10";
                end else begin
                    rt = "R9";
                    if (m_ptr < 16'd32) begin
                        e_sw = ew; e_sr = er; e_sa = m_ptr[4:0];
                        exp_rd = std_mem[m_ptr[4:0]];
                    end else begin
                        e_ew = ew; e_er = er; e_ea = m_ptr;
                        exp_rd = m_ptr ^ 16'h5AA5;
                    end
                    if (m_fn == 2'b10 || (m_fn == 2'b11 && ew)) n_ptr = m_ptr + 16'd1;
                    if (m_ptr == 16'hFFFF && n_ptr == 16'h0000) t = "R8";
                end
            end
        end else begin
            t = "R11"; e_sw = ew; e_sr = er; e_sa = a; exp_rd = std_mem[a];
        end
        if (force_tag != "") t = force_tag;
        if (rt == "") rt = t;

        @(negedge clk);
        host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
        #1;
        if (er) check(host_rdata == exp_rd, t, 64'(host_rdata), 64'(exp_rd));
        ev = {e_sw, e_sr, (e_sw | e_sr) ? e_sa : 5'd0, e_ew, e_er,
              (e_ew | e_er) ? e_ea : 16'd0, (e_sw | e_ew) ? d : 16'd0};
        av = {std_wr, std_rd, (std_wr | std_rd) ? std_addr : 5'd0, ext_wr, ext_rd,
              (ext_wr | ext_rd) ? ext_addr : 16'd0,
              std_wr ? std_wdata : (ext_wr ? ext_wdata : 16'd0)};
        check(av == ev, rt, 64'(av), 64'(ev));
        @(posedge clk);
        if (a == 5'h0D && ew) begin m_fn = d[15:14]; m_dev = d[4:0]; end
        m_ptr = n_ptr;
        #1;
        host_wr = 0; host_rd = 0;
    endtask

    // Read the pointer back through the address function and compare
    task automatic peek_ptr(input string tag);
        logic [1:0] sfn; logic [4:0] sdev;
        sfn = m_fn; sdev = m_dev;
        acc(1, 0, 5'h0D, 16'h001F, tag);
        acc(0, 1, 5'h0E, 16'h0, tag);
        acc(1, 0, 5'h0D, {sfn, 9'b0, sdev}, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [4:0] a; logic [15:0] d; logic w, r; int k;
        for (int i = 0; i < 32; i++) std_mem[i] = 16'(i * 16'h0101) ^ 16'hC3C3;
        void'($urandom(32'd7321));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset values of control and pointer
        acc(0, 1, 5'h0D, 0, "R1");
        acc(1, 0, 5'h0D, 16'h001F, "");
        acc(0, 1, 5'h0E, 0, "R1");
        // R3: wrong device address blocks the window
        acc(1, 0, 5'h0D, 16'h4015, "");
        acc(1, 0, 5'h0E, 16'h1234, "");
        acc(0, 1, 5'h0E, 0, "");
        peek_ptr("R3");
        // R2: unused control bits read zero
        acc(1, 0, 5'h0D, 16'hFFFF, "");
        acc(0, 1, 5'h0D, 0, "");
        // R4 then R6 with wrap R8
        acc(1, 0, 5'h0D, 16'h001F, "");
        acc(1, 0, 5'h0E, 16'hFFFE, "");
        acc(1, 0, 5'h0D, 16'h801F, "");
        acc(0, 1, 5'h0E, 0, "");
        acc(0, 1, 5'h0E, 0, "");
        peek_ptr("R8");
        // R7: reads do not advance, writes do
        acc(1, 0, 5'h0D, 16'h001F, "");
        acc(1, 0, 5'h0E, 16'h0100, "");
        acc(1, 0, 5'h0D, 16'hC01F, "");
        acc(0, 1, 5'h0E, 0, "");
        acc(0, 1, 5'h0E, 0, "");
        acc(1, 0, 5'h0E, 16'hBEEF, "");
        peek_ptr("R7");
        // R10 and R9 low range: pointer on own windows, then a standard reg
        acc(1, 0, 5'h0D, 16'h001F, "");
        acc(1, 0, 5'h0E, 16'h000D, "");
        acc(1, 0, 5'h0D, 16'h801F, "");
        acc(0, 1, 5'h0E, 0, "");
        acc(1, 0, 5'h0E, 16'h7777, "");
        peek_ptr("R10");
        acc(1, 0, 5'h0D, 16'h001F, "");
        acc(1, 0, 5'h0E, 16'h0003, "");
        acc(1, 0, 5'h0D, 16'h401F, "");
        acc(1, 0, 5'h0E, 16'hA1A1, "");
        acc(0, 1, 5'h0E, 0, "");
        acc(0, 1, 5'h03, 0, "R11");
        // R12: both strobes behave as a write
        acc(1, 1, 5'h05, 16'h5151, "R12");
        acc(0, 1, 5'h05, 0, "R12");
        acc(1, 1, 5'h0D, 16'h801F, "R12");
        acc(0, 1, 5'h0D, 0, "R12");

        // Seeded random mix
        for (int n = 0; n < 4000; n++) begin
            k = $urandom_range(99);
            if (k < 40)      a = 5'h0E;
            else if (k < 55) a = 5'h0D;
            else             a = 5'($urandom_range(31));
            w = ($urandom_range(1) == 1);
            r = !w || ($urandom_range(19) == 0);
            d = 16'($urandom);
            if (a == 5'h0D && $urandom_range(4) != 0) d[4:0] = 5'h1F;
            if (a == 5'h0E && m_fn == 2'b00) begin
                k = $urandom_range(9);
                if (k < 4)      d = 16'($urandom_range(39));
                else if (k < 5) d = 16'hFFF8 + 16'($urandom_range(7));
            end
            acc(w, r, a, d, "");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule